// File: doc/BRIEF.md
# Programmable Ratio Clock Divider

This block divides one input clock by a ratio held in a single 32-bit control register. The ratio field sits at a parameterized bit offset inside that register. A build-time encoding choice sets how the field value maps to the divide ratio. The four choices are: value plus one, the value itself, two raised to the value, or a lookup in a small parameter table where a zero entry marks an illegal index. Software writes the register through a simple write strobe and reads it back at any time. Register bits that the block does not use are kept as plain storage.

A write with an illegal field leaves the stored field and the running ratio untouched. It sets a sticky error bit instead. The error bit clears when software writes a 1 to it. When the commit option is built in, a legal new field is only staged. It reaches the divider when a write sets the commit bit. The divider itself is a counter. It moves to a new ratio only at the end of the current output period, so a ratio change never produces a short pulse. A ratio of 1 routes the input clock straight to the output.

Top module: `clk_ratio_divider`

## Requirements
- R1: With value-plus-one encoding, a field value f gives a divide ratio of f+1. Legal ratios lie in MIN_DIV..MAX_DIV (defaults 1 and 12, field width 4).
- R2: With direct encoding, a field value f gives a ratio of f. Field 0 is below the minimum and is rejected.
- R3: With power-of-two encoding, a field value f gives a ratio of 2^f (field width 3). Any result above MAX_DIV is rejected, so field 4 (ratio 16) is illegal.
- R4: With table encoding, field f selects entry f of the table. The default table is 4, 8, 0, 16 for fields 0..3, and the field width is 2. A zero entry makes that field illegal.
- R5: A write with an illegal field keeps the previous field readback and the previous output period. It sets the error bit, which is bit 30.
- R6: The error bit stays set until a write has bit 30 = 1. If that same write carries an illegal field, the bit remains set.
- R7: The field occupies bits [FIELD_LSB+FW-1:FIELD_LSB], with FIELD_LSB = 8 by default. All other bits except 30 and 31 read back exactly as last written, and reset to 0.
- R8: With the commit option (default top), a legal written field shows in the readback but does not change the output period. The new ratio applies only after a write with bit 31 = 1. Bit 31 always reads 0.
- R9: The output period equals the ratio in input cycles. The output is high for floor(ratio/2) cycles, which gives a 50% duty cycle for even ratios. Ratio 1 outputs the input clock.
- R10: A ratio written during an output period does not shorten or stretch that period. The new ratio starts at the next period boundary.
- R11: After reset, the error bit is 0 and the other stored bits are 0. The ratio is the smallest legal divisor of the encoding, and the field reads back as the encoding of that divisor. This gives ratio 1 with field 1 for direct encoding, and ratio 4 with field 0 for the default table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided; also clocks the register |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 32 | Data written to the control register |
| rd_data | output | 32 | Current control register contents |
| clk_out | output | 1 | Divided output clock |

## Verification
A stored field that does not match the running ratio shows up only as a wrong output period. The bench therefore times whole periods of the output, at least one full period after each write, and does not trust the readback alone. A counter or ratio register that changes at the wrong moment produces one odd-length period right at the write. Each boundary check times the single period that straddles the write. Errors in the error flag and the commit staging show at the readback and the period immediately after the offending write.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

    typedef enum logic [1:0] {
        ENC_MINUS1 = 2'd0,
        ENC_DIRECT = 2'd1,
        ENC_POW2   = 2'd2,
        ENC_TABLE  = 2'd3
    } div_enc_e;

    localparam int TBL_EW = 16;

    function automatic int field_width(div_enc_e enc, int max_div, int tbl_len);
        int w;
        case (enc)
            ENC_TABLE: w = $clog2(tbl_len);
            ENC_POW2:  w = $clog2($clog2(max_div) + 1);
            default:   w = $clog2(max_div + 1);
        endcase
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/clkdiv_decode.sv
`timescale 1ns/1ps
module clkdiv_decode
    import clkdiv_pkg::*;
#(
    parameter div_enc_e ENC = ENC_MINUS1,
    parameter int FW = 4,
    parameter int RW = 8,
    parameter int MIN_DIV = 1,
    parameter int MAX_DIV = 12,
    parameter int TBL_LEN = 4,
    parameter logic [TBL_LEN*TBL_EW-1:0] TBL = '0
) (
    input  logic [FW-1:0] field_i,
    output logic [RW-1:0] ratio_o,
    output logic          valid_o,
    output logic [FW-1:0] rst_field_o,
    output logic [RW-1:0] rst_ratio_o
);
    localparam int NCODES = 1 << FW;

    // Returns {legal, ratio} for one field code.
    function automatic logic [RW:0] map_field(input logic [FW-1:0] f);
        logic [63:0] r;
        logic        ok;
        r = '0;
        if (ENC == ENC_TABLE) begin
            for (int k = 0; k < TBL_LEN; k++) begin
                if (int'(f) == k) r = 64'(TBL[k*TBL_EW +: TBL_EW]);
            end
            ok = (r != '0);
        end else begin
            case (ENC)
                ENC_DIRECT: r = 64'(f);
                ENC_POW2:   r = 64'd1 << f;
                default:    r = 64'(f) + 64'd1;
            endcase
            ok = (r >= 64'(MIN_DIV)) && (r <= 64'(MAX_DIV));
        end
        return {ok, r[RW-1:0]};
    endfunction

    logic [RW:0] live;

    always_comb begin
        live    = map_field(field_i);
        valid_o = live[RW];
        ratio_o = live[RW-1:0];
    end

    // Smallest legal ratio, lowest code on a tie; this is the reset setting.
    always_comb begin
        logic [RW:0] m;
        logic        found;
        found       = 1'b0;
        rst_field_o = '0;
        rst_ratio_o = RW'(1);
        for (int i = NCODES - 1; i >= 0; i--) begin
            m = map_field(FW'(i));
            if (m[RW] && (!found || m[RW-1:0] <= rst_ratio_o)) begin
                found       = 1'b1;
                rst_field_o = FW'(i);
                rst_ratio_o = m[RW-1:0];
            end
        end
    end

endmodule

// File: rtl/clkdiv_regs.sv
`timescale 1ns/1ps
module clkdiv_regs #(
    parameter int FW = 4,
    parameter int RW = 8,
    parameter int FIELD_LSB = 8,
    parameter bit USE_LATCH = 1'b1,
    parameter int LATCH_BIT = 31,
    parameter int ERR_BIT = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [31:0]   wr_data,
    input  logic [RW-1:0] dec_ratio,
    input  logic          dec_valid,
    input  logic [FW-1:0] rst_field,
    input  logic [RW-1:0] rst_ratio,
    output logic [31:0]   rd_data,
    output logic [RW-1:0] pend_ratio
);
    localparam logic [31:0] FIELD_MASK = 32'(((64'd1 << FW) - 64'd1) << FIELD_LSB);
    localparam logic [31:0] ERR_MASK   = 32'd1 << ERR_BIT;
    localparam logic [31:0] LATCH_MASK = USE_LATCH ? (32'd1 << LATCH_BIT) : 32'd0;
    localparam logic [31:0] MISC_MASK  = ~(FIELD_MASK | ERR_MASK | LATCH_MASK);

    typedef struct packed {
        logic [FW-1:0] fld;
        logic [RW-1:0] stg;
        logic [RW-1:0] pend;
        logic          err;
        logic [31:0]   misc;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic    commit;

    generate
        if (USE_LATCH) begin : g_latch
            assign commit = wr_en & wr_data[LATCH_BIT];
        end else begin : g_direct
            assign commit = 1'b1;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.misc = wr_data & MISC_MASK;
            if (dec_valid) begin
                st_d.fld = wr_data[FIELD_LSB +: FW];
                st_d.stg = dec_ratio;
            end
            if (wr_data[ERR_BIT]) st_d.err = 1'b0;
            if (!dec_valid)       st_d.err = 1'b1;
        end
        if (commit) st_d.pend = st_d.stg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fld  <= rst_field;
            st_q.stg  <= rst_ratio;
            st_q.pend <= rst_ratio;
            st_q.err  <= 1'b0;
            st_q.misc <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data    = st_q.misc | (32'(st_q.fld) << FIELD_LSB) | (32'(st_q.err) << ERR_BIT);
    assign pend_ratio = st_q.pend;

    logic [FW-1:0] fld_q;
    logic [RW-1:0] pend_q;
    logic          err_q;
    assign fld_q  = st_q.fld;
    assign pend_q = st_q.pend;
    assign err_q  = st_q.err;

    // R5
    bad_write_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dec_valid) |=> err_q)
        else $error("illegal field did not raise the error bit");

    // R5
    bad_write_keeps_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !dec_valid) |=> $stable(fld_q))
        else $error("illegal field altered the stored field");

    // R6
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dec_valid && wr_data[ERR_BIT]) |=> !err_q)
        else $error("error bit not cleared by write of one");

    generate
        if (USE_LATCH) begin : g_latch_chk
            // R8
            no_commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && wr_data[LATCH_BIT]) |=> $stable(pend_q))
                else $error("pending ratio moved without commit");
        end
    endgenerate

endmodule

// File: rtl/clkdiv_gen.sv
`timescale 1ns/1ps
module clkdiv_gen #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] rst_ratio,
    input  logic [RW-1:0] pend_ratio,
    output logic          clk_out
);
    typedef struct packed {
        logic [RW-1:0] cnt;
        logic [RW-1:0] act;
        logic          out;
    } gen_st_t;

    gen_st_t gs_d, gs_q;
    logic    wrap;

    always_comb begin
        gs_d = gs_q;
        wrap = (gs_q.cnt == gs_q.act - RW'(1));
        if (wrap) begin
            gs_d.cnt = '0;
            gs_d.act = pend_ratio;
        end else begin
            gs_d.cnt = gs_q.cnt + RW'(1);
        end
        gs_d.out = (gs_d.cnt < (gs_d.act >> 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gs_q.cnt <= '0;
            gs_q.act <= rst_ratio;
            gs_q.out <= (rst_ratio > RW'(1));
        end else begin
            gs_q <= gs_d;
        end
    end

    assign clk_out = (gs_q.act == RW'(1)) ? clk : gs_q.out;

    logic [RW-1:0] cnt_q, act_q;
    assign cnt_q = gs_q.cnt;
    assign act_q = gs_q.act;

    // R10
    ratio_moves_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_q) |-> ($past(cnt_q) == $past(act_q) - RW'(1)))
        else $error("active ratio changed inside a period");

    // R9
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < act_q)
        else $error("period counter beyond ratio");

endmodule

// File: rtl/clk_ratio_divider.sv
`timescale 1ns/1ps
module clk_ratio_divider
    import clkdiv_pkg::*;
#(
    parameter div_enc_e ENC = ENC_MINUS1,
    parameter int FIELD_LSB = 8,
    parameter int MIN_DIV = 1,
    parameter int MAX_DIV = 12,
    parameter int RW = 8,
    parameter int TBL_LEN = 4,
    parameter logic [TBL_LEN*TBL_EW-1:0] TBL = {16'd16, 16'd0, 16'd8, 16'd4},
    parameter bit USE_LATCH = 1'b1,
    parameter int LATCH_BIT = 31,
    parameter int ERR_BIT = 30
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wr_data,
    output logic [31:0] rd_data,
    output logic        clk_out
);
    localparam int FW = field_width(ENC, MAX_DIV, TBL_LEN);

    logic [FW-1:0] wr_field, rst_field;
    logic [RW-1:0] dec_ratio, rst_ratio, pend_ratio;
    logic          dec_valid;

    assign wr_field = wr_data[FIELD_LSB +: FW];

    clkdiv_decode #(
        .ENC(ENC), .FW(FW), .RW(RW), .MIN_DIV(MIN_DIV), .MAX_DIV(MAX_DIV),
        .TBL_LEN(TBL_LEN), .TBL(TBL)
    ) u_decode (
        .field_i(wr_field), .ratio_o(dec_ratio), .valid_o(dec_valid),
        .rst_field_o(rst_field), .rst_ratio_o(rst_ratio)
    );

    clkdiv_regs #(
        .FW(FW), .RW(RW), .FIELD_LSB(FIELD_LSB), .USE_LATCH(USE_LATCH),
        .LATCH_BIT(LATCH_BIT), .ERR_BIT(ERR_BIT)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .dec_ratio(dec_ratio), .dec_valid(dec_valid),
        .rst_field(rst_field), .rst_ratio(rst_ratio),
        .rd_data(rd_data), .pend_ratio(pend_ratio)
    );

    clkdiv_gen #(.RW(RW)) u_gen (
        .clk(clk), .rst_n(rst_n), .rst_ratio(rst_ratio),
        .pend_ratio(pend_ratio), .clk_out(clk_out)
    );

endmodule

// File: tb/clk_ratio_divider_tb.sv
`timescale 1ns/1ps
module clk_ratio_divider_tb;
    import clkdiv_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  we = '0;
    logic [31:0] wd = '0;
    logic [31:0] rd [4];
    logic [3:0]  co;
    int          sel = 0;
    logic        cm;
    int          nvec = 0;
    int          nbad = 0;

    always #2 clk = ~clk;
    assign cm = co[sel];

    clk_ratio_divider u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(we[0]), .wr_data(wd), .rd_data(rd[0]), .clk_out(co[0]));
    clk_ratio_divider #(.ENC(ENC_DIRECT), .USE_LATCH(1'b0)) u_dut_dir (
        .clk(clk), .rst_n(rst_n), .wr_en(we[1]), .wr_data(wd), .rd_data(rd[1]), .clk_out(co[1]));
    clk_ratio_divider #(.ENC(ENC_POW2), .USE_LATCH(1'b0)) u_dut_p2 (
        .clk(clk), .rst_n(rst_n), .wr_en(we[2]), .wr_data(wd), .rd_data(rd[2]), .clk_out(co[2]));
    clk_ratio_divider #(.ENC(ENC_TABLE), .USE_LATCH(1'b0)) u_dut_tbl (
        .clk(clk), .rst_n(rst_n), .wr_en(we[3]), .wr_data(wd), .rd_data(rd[3]), .clk_out(co[3]));

    // Expected ratio per encoding; 0 means illegal.
    function automatic int exp_ratio(int idx, int f);
        int r;
        case (idx)
            0: r = f + 1;
            1: r = f;
            2: r = 1 << f;
            default: case (f) 0: r = 4; 1: r = 8; 3: r = 16; default: r = 0; endcase
        endcase
        if (idx != 3 && (r < 1 || r > 12)) r = 0;
        return r;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(int idx, logic [31:0] d);
        @(negedge clk);
        we[idx] = 1'b1;
        wd = d;
        @(negedge clk);
        we = '0;
    endtask

    task automatic measure(int idx, output int per, output int hi);
        realtime t1, t2, t3;
        sel = idx;
        @(posedge cm);
        @(posedge cm);
        t1 = $realtime;
        @(negedge cm);
        t2 = $realtime;
        @(posedge cm);
        t3 = $realtime;
        per = int'((t3 - t1) / 4.0);
        hi  = int'((t2 - t1) / 4.0);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        nbad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int per, hi, er, mrat, merr;
        logic [3:0] mfld, f;
        logic [31:0] misc, d;
        realtime t0, t1;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11 reset state of each encoding
        chk("R11 minus1 rd", rd[0], 32'h0);
        chk("R11 direct rd", rd[1], 32'h100);
        chk("R11 pow2 rd",   rd[2], 32'h0);
        chk("R11 table rd",  rd[3], 32'h0);
        measure(0, per, hi); chk("R11 minus1 period", per, 1);
        measure(1, per, hi); chk("R11 direct period", per, 1);
        measure(2, per, hi); chk("R11 pow2 period", per, 1);
        measure(3, per, hi); chk("R11 table period", per, 4);

        // R8 staged write does not reach the divider
        wr(0, 32'h0000_0500);
        chk("R8 staged rd", rd[0], 32'h500);
        measure(0, per, hi); chk("R8 staged period", per, 1);
        wr(0, 32'h8000_0500);
        chk("R8 commit bit reads 0", rd[0], 32'h500);
        measure(0, per, hi);
        chk("R8 committed period", per, 6);
        chk("R9 even duty", hi, 3);

        // R10 change mid-period: the straddling period keeps the old ratio
        sel = 0;
        @(posedge cm);
        t0 = $realtime;
        wr(0, 32'h8000_0200);
        @(posedge cm);
        t1 = $realtime;
        chk("R10 straddling period", int'((t1 - t0) / 4.0), 6);
        measure(0, per, hi);
        chk("R10 next period", per, 3);
        chk("R9 odd high time", hi, 1);

        // R5 out-of-range field
        wr(0, 32'h8000_0D00);
        chk("R5 rd after bad", rd[0], 32'h4000_0200);
        measure(0, per, hi); chk("R5 period kept", per, 3);

        // R6 sticky, write-one-to-clear, set dominates
        wr(0, 32'h0000_0200);
        chk("R6 sticky", rd[0], 32'h4000_0200);
        wr(0, 32'h4000_0200);
        chk("R6 cleared", rd[0], 32'h0000_0200);
        wr(0, 32'h4000_0F00);
        chk("R6 set dominates", rd[0], 32'h4000_0200);
        wr(0, 32'h4000_0200);
        chk("R6 cleared again", rd[0], 32'h0000_0200);

        // R7 other bits are storage; R8 field 3 not committed
        wr(0, 32'h2A5A_0355);
        chk("R7 misc readback", rd[0], 32'h2A5A_0355);
        measure(0, per, hi); chk("R8 uncommitted period", per, 3);

        // R2 direct encoding
        wr(1, 32'h0000_0700);
        chk("R2 rd 7", rd[1], 32'h700);
        measure(1, per, hi); chk("R2 period 7", per, 7);
        wr(1, 32'h0000_0000);
        chk("R2 field 0 rejected", rd[1], 32'h4000_0700);
        measure(1, per, hi); chk("R2 period kept", per, 7);

        // R3 power-of-two encoding
        for (int k = 0; k <= 4; k++) begin
            wr(2, 32'(k) << 8);
            if (k < 4) begin
                chk("R3 rd", rd[2], 32'(k) << 8);
                measure(2, per, hi); chk("R3 period", per, 1 << k);
            end else begin
                chk("R3 field 4 rejected", rd[2], 32'h4000_0300);
                measure(2, per, hi); chk("R3 period kept", per, 8);
            end
        end

        // R4 table encoding
        wr(3, 32'h0000_0100);
        measure(3, per, hi); chk("R4 entry 1", per, 8);
        wr(3, 32'h0000_0200);
        chk("R4 zero entry rejected", rd[3], 32'h4000_0100);
        measure(3, per, hi); chk("R4 period kept", per, 8);
        wr(3, 32'h0000_0300);
        measure(3, per, hi); chk("R4 entry 3", per, 16);
        wr(3, 32'h0000_0000);
        measure(3, per, hi); chk("R4 entry 0", per, 4);

        // R1 random fields with commit on the default instance
        mfld = 4'd3; mrat = 4; merr = 0;
        for (int i = 0; i < 24; i++) begin
            f    = 4'($urandom_range(15, 0));
            misc = $urandom & 32'h3FFF_F0FF;
            d    = misc | (32'(f) << 8) | 32'h8000_0000;
            er   = exp_ratio(0, int'(f));
            if (er != 0) begin mfld = f; mrat = er; end else merr = 1;
            wr(0, d);
            chk("R1 rd", rd[0], misc | (32'(mfld) << 8) | (32'(merr) << 30));
            measure(0, per, hi);
            chk("R1 period", per, mrat);
            if (mrat > 1 && mrat % 2 == 0) chk("R9 duty", hi, mrat / 2);
            if (i % 5 == 4) begin
                wr(0, 32'h4000_0000 | (32'(mfld) << 8));
                merr = 0;
            end
        end

        summary();
    end

endmodule